// File: doc/BRIEF.md
# Indirect Byte Register Access Bridge

This bridge lets a 32-bit host register window reach a private register file that has 8-bit addresses and 8-bit data and sits inside a protocol core. The core's registers are not mapped into the host space one by one. Instead, the host uses a single command/status word. One host write to that word carries the target byte address, the byte to store and the transfer direction. The bridge then runs a single access on the internal byte bus and holds a busy flag until the internal side answers with ready.

Software polls the busy bit. Once it clears, a read result sits in the top byte of the same word. The other fields echo the command that was last accepted. A new command that arrives while an access is still open is dropped, so the open access completes untouched. The internal register file itself is outside the block. The bench supplies a model of it with a latency that can be set anywhere from 2 to 8 cycles.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the command word reads as all zeros and no internal access is requested.
- R2: Only host offset 0x0C (32-bit registers on a 4-byte stride) holds the command word. Any other offset reads as zero, and a write to it starts no access.
- R3: Command word fields: bits [7:0] byte address, bits [15:8] write byte, bit 16 direction (1 = write, 0 = read). A write command stores its byte at its address in the internal register file, and the accepted fields read back in the same positions.
- R4: Busy (bit 23) is set in the cycle after an accepted command write and clears on the clock edge where the internal bus gives ready. With ready in the L-th cycle of the request, busy reads as 1 for exactly L cycles.
- R5: While an access is open, the internal request stays asserted, and its address, write byte and direction stay stable until ready.
- R6: A read command (bit 16 clear) returns the addressed byte in bits [31:24] once busy has cleared.
- R7: Bits [31:24] keep the last completed read value while a later access is still in progress.
- R8: When a write command completes, bits [31:24] read as zero.
- R9: A command write that arrives while busy is set is ignored. The echoed fields, the open access and the internal register file are all unaffected.
- R10: Bits [22:17] of the command word always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 8 | Host byte offset into the register window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| int_req | output | 1 | Internal access request, held until ready |
| int_we | output | 1 | Internal access direction, 1 = write |
| int_addr | output | 8 | Internal byte address |
| int_wdata | output | 8 | Internal write byte |
| int_rdata | input | 8 | Internal read byte, valid with int_ready |
| int_ready | input | 1 | Internal access completion |

## Verification
A table of commands alternates byte writes and read-backs. It covers the extreme addresses 0x00 and 0xFF, an address that has never been written, and latencies of 2 through 8. Measuring how many cycles busy stays high shows whether completion is tied to ready rather than to a fixed count. Reading a byte after a different address was written separates address decoding from data routing. Directed cases then issue a command during an open access, write to a neighbouring offset, and write an all-ones word. These three cases tell a dropped command apart from one that overwrote the access in flight, and a held read byte apart from one that was refreshed early.

// File: rtl/ibr_pkg.sv
`timescale 1ns/1ps
package ibr_pkg;

    localparam int BYTE_AW   = 8;
    localparam int BYTE_DW   = 8;
    localparam int WORD_W    = 32;

    // bit positions of the command/status word (decoded by software)
    localparam int POS_ADDR  = 0;
    localparam int POS_WDATA = 8;
    localparam int POS_WE    = 16;
    localparam int POS_BUSY  = 23;
    localparam int POS_RBYTE = 24;

    localparam logic [7:0] CMD_WORD_OFS = 8'h0C;

    typedef struct packed {
        logic               we;
        logic [BYTE_DW-1:0] wdata;
        logic [BYTE_AW-1:0] addr;
    } byte_cmd_t;

    function automatic byte_cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
        byte_cmd_t c;
        c.addr  = w[POS_ADDR  +: BYTE_AW];
        c.wdata = w[POS_WDATA +: BYTE_DW];
        c.we    = w[POS_WE];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input byte_cmd_t c,
                                                      input logic busy,
                                                      input logic [BYTE_DW-1:0] rb);
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_ADDR  +: BYTE_AW] = c.addr;
        w[POS_WDATA +: BYTE_DW] = c.wdata;
        w[POS_WE]               = c.we;
        w[POS_BUSY]             = busy;
        w[POS_RBYTE +: BYTE_DW] = rb;
        return w;
    endfunction

endpackage

// File: rtl/ibr_host_decode.sv
`timescale 1ns/1ps
module ibr_host_decode
    import ibr_pkg::*;
#(
    parameter int          HOST_AW = 8,
    parameter logic [7:0]  CMD_OFS = CMD_WORD_OFS
)(
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    input  logic [WORD_W-1:0]  status_word,
    output logic               cmd_wr,
    output byte_cmd_t          cmd_in,
    output logic [WORD_W-1:0]  host_rdata
);
    localparam logic [HOST_AW-1:0] HIT_ADDR = HOST_AW'(CMD_OFS);

    logic hit;

    always_comb begin
        hit        = (host_addr == HIT_ADDR);
        cmd_wr     = host_wr && hit;
        cmd_in     = unpack_cmd(host_wdata);
        host_rdata = hit ? status_word : '0;
    end

endmodule

// File: rtl/ibr_access_seq.sv
`timescale 1ns/1ps
module ibr_access_seq
    import ibr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_wr,
    input  byte_cmd_t          cmd_in,
    input  logic               int_ready,
    input  logic [BYTE_DW-1:0] int_rdata,
    output byte_cmd_t          cur_cmd,
    output logic               busy,
    output logic [BYTE_DW-1:0] rd_byte,
    output logic               int_req,
    output logic               int_we,
    output logic [BYTE_AW-1:0] int_addr,
    output logic [BYTE_DW-1:0] int_wdata
);
    typedef enum logic {ST_IDLE, ST_ACCESS} seq_st_t;

    seq_st_t st;
    logic    accept;
    logic    finish;

    always_comb begin
        accept = cmd_wr && (st == ST_IDLE);
        finish = (st == ST_ACCESS) && int_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cur_cmd <= '0;
            rd_byte <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    cur_cmd <= cmd_in;
                    st      <= ST_ACCESS;
                end
                ST_ACCESS: if (finish) begin
                    rd_byte <= cur_cmd.we ? '0 : int_rdata;
                    st      <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st == ST_ACCESS);
        int_req   = busy;
        int_we    = cur_cmd.we;
        int_addr  = cur_cmd.addr;
        int_wdata = cur_cmd.wdata;
    end

    // R5: request fields frozen while the access is open
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (int_req && !int_ready) |=> (int_req && $stable(int_addr) &&
                                     $stable(int_wdata) && $stable(int_we)));

    // R9: a command during an open access leaves the latched command alone
    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> (cur_cmd == $past(cur_cmd)));

    // R7: read byte only moves on a completion edge
    assert_rbyte_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && int_ready) |=> $stable(rd_byte));

    // R8: completed write clears the read byte
    assert_wr_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && int_ready && int_we) |=> (rd_byte == '0));

endmodule

// File: rtl/ibr_bridge.sv
`timescale 1ns/1ps
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int         HOST_AW = 8,
    parameter logic [7:0] CMD_OFS = CMD_WORD_OFS
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               int_req,
    output logic               int_we,
    output logic [7:0]         int_addr,
    output logic [7:0]         int_wdata,
    input  logic [7:0]         int_rdata,
    input  logic               int_ready
);
    logic               cmd_wr;
    byte_cmd_t          cmd_in;
    byte_cmd_t          cur_cmd;
    logic               busy;
    logic [BYTE_DW-1:0] rd_byte;
    logic [WORD_W-1:0]  status_word;

    assign status_word = pack_status(cur_cmd, busy, rd_byte);

    ibr_host_decode #(.HOST_AW(HOST_AW), .CMD_OFS(CMD_OFS)) u_dec (
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .status_word (status_word),
        .cmd_wr      (cmd_wr),
        .cmd_in      (cmd_in),
        .host_rdata  (host_rdata)
    );

    ibr_access_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd_in    (cmd_in),
        .int_ready (int_ready),
        .int_rdata (int_rdata),
        .cur_cmd   (cur_cmd),
        .busy      (busy),
        .rd_byte   (rd_byte),
        .int_req   (int_req),
        .int_we    (int_we),
        .int_addr  (int_addr),
        .int_wdata (int_wdata)
    );

    // R4: busy rises only after an accepted command word write
    assert_busy_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_wr));

    // R4: busy falls only on a ready edge
    assert_busy_end_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(int_ready));

    // R2: writes outside the command offset start nothing
    assert_offset_only_R2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr != HOST_AW'(CMD_OFS) && !busy) |=> !busy);

endmodule

// File: tb/sim_ibr_bridge.sv
`timescale 1ns/1ps
module sim_ibr_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr;
    logic [7:0]  host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        int_req, int_we, int_ready;
    logic [7:0]  int_addr, int_wdata, int_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ibr_bridge u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .int_req(int_req),
        .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
        .int_rdata(int_rdata), .int_ready(int_ready)
    );

    // ---- internal register file model with settable latency ----
    logic [7:0] mem [256];
    int         lat_cfg = 2;
    int         lat_cnt;

    assign int_ready = int_req && (lat_cnt == lat_cfg - 1);
    assign int_rdata = mem[int_addr];

    always_ff @(posedge clk) begin
        if (rst || !int_req || int_ready) lat_cnt <= 0;
        else                              lat_cnt <= lat_cnt + 1;
        if (int_req && int_ready && int_we) mem[int_addr] <= int_wdata;
    end

    // ---- R5 port monitor ----
    bit         r5_bad = 1'b0;
    logic       prev_open = 1'b0;
    logic [16:0] prev_req_f;
    always @(negedge clk) begin
        if (prev_open && int_req && {int_we, int_wdata, int_addr} != prev_req_f)
            r5_bad = 1'b1;
        prev_open  <= int_req && !int_ready;
        prev_req_f <= {int_we, int_wdata, int_addr};
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
        host_addr  = 8'h0C;
    endtask

    // counts negedge samples with busy high, 0 = timeout
    task automatic busy_len(output int n);
        n = 0;
        while (host_rdata[23] && n < 100) begin
            n++;
            @(negedge clk);
        end
        if (n >= 100) n = 0;
    endtask

    // vector: {we, addr, wdata, latency, expected read byte}
    localparam int NV = 9;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 8'h10, 8'hA5, 4'd2, 8'h00},
        {1'b1, 8'hFF, 8'h3C, 4'd8, 8'h00},
        {1'b0, 8'h10, 8'h00, 4'd3, 8'hA5},
        {1'b0, 8'hFF, 8'h00, 4'd8, 8'h3C},
        {1'b1, 8'h00, 8'h81, 4'd5, 8'h00},
        {1'b0, 8'h00, 8'h00, 4'd2, 8'h81},
        {1'b0, 8'h42, 8'h00, 4'd4, 8'h00},
        {1'b1, 8'h42, 8'h7E, 4'd6, 8'h00},
        {1'b0, 8'h42, 8'h00, 4'd7, 8'h7E}
    };

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] snap;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        rst = 1'b1; host_wr = 1'b0; host_addr = 8'h0C; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(host_rdata == 32'h0, "R1 word", host_rdata, 32'h0);
        check(int_req == 1'b0, "R1 req", {31'h0, int_req}, 32'h0);

        // main table
        for (int v = 0; v < NV; v++) begin
            logic        we;
            logic [7:0]  a, d, e;
            logic [3:0]  l;
            {we, a, d, l, e} = VEC[v];
            lat_cfg = int'(l);
            host_write(8'h0C, {8'h00, 7'h0, we, d, a});
            // R3: accepted fields echo
            check(host_rdata[16:0] == {we, d, a}, "R3 echo", {15'h0, host_rdata[16:0]},
                  {15'h0, we, d, a});
            busy_len(n);
            // R4: busy length equals latency
            check(n == int'(l), "R4 busy length", n, {28'h0, l});
            // R6 / R8: read byte after completion
            check(host_rdata[31:24] == e, we ? "R8 write zero" : "R6 read byte",
                  {24'h0, host_rdata[31:24]}, {24'h0, e});
        end
        // R3: write landed in register file
        check(mem[8'hFF] == 8'h3C, "R3 store", {24'h0, mem[8'hFF]}, 32'h3C);

        // R7: old read byte visible while a later read is open
        lat_cfg = 8;
        host_write(8'h0C, 32'h0000_0010);
        @(negedge clk); @(negedge clk);
        check(host_rdata[23] && host_rdata[31:24] == 8'h7E, "R7 hold",
              host_rdata, {8'h7E, 24'h800010});
        busy_len(n);
        check(host_rdata[31:24] == 8'hA5, "R7 update", {24'h0, host_rdata[31:24]}, 32'hA5);

        // R9: command during busy is dropped
        lat_cfg = 6;
        host_write(8'h0C, 32'h0000_0000);
        @(negedge clk);
        host_write(8'h0C, 32'h0001_1110);
        check(host_rdata[16:0] == 17'h0, "R9 echo", {15'h0, host_rdata[16:0]}, 32'h0);
        busy_len(n);
        check(host_rdata[31:24] == 8'h81, "R9 open access", {24'h0, host_rdata[31:24]}, 32'h81);
        check(mem[8'h10] == 8'hA5, "R9 file untouched", {24'h0, mem[8'h10]}, 32'hA5);

        // R2: other offset ignored
        snap = host_rdata;
        host_write(8'h08, 32'h0001_5520);
        check(host_rdata[23] == 1'b0, "R2 no start", host_rdata, snap);
        host_addr = 8'h08;
        #1;
        check(host_rdata == 32'h0, "R2 other reads zero", host_rdata, 32'h0);
        host_addr = 8'h0C;
        #1;
        check(host_rdata == snap, "R2 word unchanged", host_rdata, snap);
        check(mem[8'h20] == 8'h00, "R2 file untouched", {24'h0, mem[8'h20]}, 32'h0);

        // R10: reserved bits read zero even with all-ones written
        lat_cfg = 2;
        host_write(8'h0C, 32'hFFFF_FFFF);
        check(host_rdata[22:17] == 6'h0, "R10 reserved", host_rdata, {host_rdata[31:23], 6'h0, host_rdata[16:0]});
        busy_len(n);
        check(host_rdata == 32'h0001_FFFF, "R10 final word", host_rdata, 32'h0001_FFFF);

        check(!r5_bad, "R5 request stable", {31'h0, r5_bad}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule